// File: doc/BRIEF.md
# Page Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations so that a memory access can be translated without consulting the page table. Each access presents a 32-bit virtual address and a process identifier. The block compares them against every stored entry at once and, on a match, returns the 30-bit physical address combinationally in the same cycle. Pages are 2 KB, so the low 11 address bits are the page offset and are passed through unchanged. The upper 21 bits are the virtual page number, and a 19-bit physical page number replaces them.

When no entry matches, the block raises a walk request toward an external page-table walker, which may end in a page fault handled elsewhere. When the walk finishes, the walker returns a refill. The refill carries a permission verdict. A permitted refill is stored. A refused refill is dropped and reported as a protection fault. A flush input, used on a task switch, empties the whole buffer in one cycle. An untranslated mode serves privileged accesses: the low 30 virtual bits are used directly and the stored entries are not consulted.

The entry count is a parameter with a default of 16 and a range of 8 to 32. By default, a full buffer gives up its least recently used entry on refill. A parameter selects pseudo-random eviction from a free-running shift register instead.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no entry is valid, so every translated lookup misses.
- R2: A lookup (lk_valid=1, lk_bypass=0) whose vaddr[31:11] and pid equal a valid entry's page number and pid asserts lk_hit in the same cycle. In that cycle lk_paddr = {entry ppn, vaddr[10:0]}.
- R3: A translated lookup with no matching entry holds lk_hit=0 and lk_paddr=0. It asserts walk_req with walk_vpn = vaddr[31:11] and walk_pid = lk_pid.
- R4: An entry is matched only when the process identifier also agrees. The same page number under another pid misses.
- R5: A refill with fill_valid=1 and fill_allowed=1 stores {fill_vpn, fill_pid, fill_ppn}. The stored entry can be looked up from the next cycle.
- R6: A refill with fill_allowed=0 asserts prot_fault in the same cycle and changes no entry.
- R7: flush=1 invalidates every entry from the next cycle. A refill in the same cycle as a flush is discarded.
- R8: A refill goes into the lowest-numbered invalid entry before any valid entry is evicted.
- R9: With the default replacement, a full buffer evicts the entry least recently used. Hits and refills both count as use. When both occur in one cycle, the refill counts as the more recent use.
- R10: A refill whose page number and pid match a valid entry overwrites that entry in place, so no translation is ever held twice.
- R11: An untranslated lookup (lk_bypass=1) drives lk_paddr = vaddr[29:0] with lk_hit=0 and walk_req=0. It does not change use order.
- R12: A lookup sees the buffer contents and use order from the start of its cycle. A refill or flush in that cycle takes effect only afterwards, and the victim is chosen from the use order at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_bypass | input | 1 | Untranslated (privileged) access |
| lk_vaddr | input | 32 | Virtual address |
| lk_pid | input | 8 | Process identifier of the access |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 30 | Physical address |
| walk_req | output | 1 | Miss: request to the page-table walker |
| walk_vpn | output | 21 | Page number to walk |
| walk_pid | output | 8 | Process identifier to walk |
| fill_valid | input | 1 | Refill from the walker present |
| fill_allowed | input | 1 | Walker verified access to the page |
| fill_vpn | input | 21 | Refill virtual page number |
| fill_pid | input | 8 | Refill process identifier |
| fill_ppn | input | 19 | Refill physical page number |
| prot_fault | output | 1 | Refill refused for lack of permission |
| flush | input | 1 | Task-switch flush of all entries |

## Verification
A lookup and a refill can land in the same cycle, and so can a refill and a flush. The bench drives a hit on a full buffer together with a refill, and a flush together with a permitted refill, in directed cycles. A long random phase then mixes all four operations freely. A behavioural model keeps the entries and a move-to-front use list. It applies the lookup touch before the refill touch, chooses the victim from the list as it stood before the cycle, and lets a flush discard the refill. Its hit, address, walk and fault outputs are compared with the block's on every clock.

// File: rtl/xlb_pkg.sv
package xlb_pkg;

    localparam int VA_W  = 32;
    localparam int PA_W  = 30;
    localparam int OFF_W = 11;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int PID_W = 8;
    localparam int AGE_W = 6;
    localparam int RNG_W = 16;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [PID_W-1:0] pid_t;
    typedef logic [AGE_W-1:0] age_t;

    typedef enum logic {
        REPL_LRU    = 1'b0,
        REPL_RANDOM = 1'b1
    } repl_e;

    typedef struct packed {
        vpn_t vpn;
        pid_t pid;
        ppn_t ppn;
    } xlb_entry_t;

    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Rank of one entry after a move-to-front of the target entry.
    function automatic age_t age_after_touch(input age_t mine, input age_t tgt_age,
                                             input logic is_tgt, input logic en);
        if (!en)
            return mine;
        if (is_tgt)
            return '0;
        if (mine < tgt_age)
            return age_t'(mine + 1'b1);
        return mine;
    endfunction

endpackage

// File: rtl/xlb_match.sv
module xlb_match
    import xlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  xlb_entry_t    ents [N],
    input  vpn_t          key_vpn,
    input  pid_t          key_pid,
    output logic [N-1:0]  hit_vec,
    output logic          any_hit,
    output logic [IDX_W-1:0] hit_idx
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = valid[i] && (ents[i].vpn == key_vpn) && (ents[i].pid == key_pid);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++)
            if (hit_vec[i])
                hit_idx = hit_idx | IDX_W'(i);
    end

endmodule

// File: rtl/xlb_recency.sv
module xlb_recency
    import xlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ta_en,
    input  logic [IDX_W-1:0] ta_idx,
    input  logic             tb_en,
    input  logic [IDX_W-1:0] tb_idx,
    output logic [IDX_W-1:0] lru_idx
);

    age_t       age_q [N];
    logic [N-1:0] oldest;
    age_t       a_ref;
    age_t       b_ref;

    // Touch A (lookup) is applied first, touch B (refill) on top of it.
    assign a_ref = age_q[ta_idx];
    assign b_ref = age_after_touch(age_q[tb_idx], a_ref, tb_idx == ta_idx, ta_en);

    for (genvar i = 0; i < N; i++) begin : g_age
        age_t mid;
        assign mid       = age_after_touch(age_q[i], a_ref, IDX_W'(i) == ta_idx, ta_en);
        assign oldest[i] = (age_q[i] == AGE_W'(N - 1));
        always_ff @(posedge clk) begin
            if (rst)
                age_q[i] <= AGE_W'(i);
            else
                age_q[i] <= age_after_touch(mid, b_ref, IDX_W'(i) == tb_idx, tb_en);
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++)
            if (oldest[i])
                lru_idx = IDX_W'(i);
    end

    // R9: ranks stay a permutation, so exactly one entry is oldest
    a_r9_single_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest) == 1);

endmodule

// File: rtl/xlb_victim.sv
module xlb_victim
    import xlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic             dup_any,
    input  logic [IDX_W-1:0] dup_idx,
    input  logic [IDX_W-1:0] repl_idx,
    output logic             has_free,
    output logic [IDX_W-1:0] vic_idx
);

    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (!valid[i])
                free_idx = IDX_W'(i);
    end

    assign has_free = ~&valid;

    always_comb begin
        if (dup_any)
            vic_idx = dup_idx;
        else if (has_free)
            vic_idx = free_idx;
        else
            vic_idx = repl_idx;
    end

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlb_pkg::*;
#(
    parameter int    N    = 16,
    parameter repl_e REPL = REPL_LRU
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic             lk_bypass,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] lk_pid,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    output logic [PID_W-1:0] walk_pid,
    input  logic             fill_valid,
    input  logic             fill_allowed,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PPN_W-1:0] fill_ppn,
    output logic             prot_fault,
    input  logic             flush
);

    localparam int IDX_W = $clog2(N);

    xlb_entry_t       ents_q [N];
    logic [N-1:0]     valid_q;

    logic [N-1:0]     lk_vec;
    logic             lk_any;
    logic [IDX_W-1:0] lk_idx;
    logic [N-1:0]     dup_vec;
    logic             dup_any;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] lru_idx;
    logic [IDX_W-1:0] repl_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             has_free;
    logic             translate;
    logic             fill_ok;
    vpn_t             lk_vpn;

    assign lk_vpn    = lk_vaddr[VA_W-1:OFF_W];
    assign translate = lk_valid && !lk_bypass;
    assign fill_ok   = fill_valid && fill_allowed && !flush;

    // ---------------- lookup path ----------------
    xlb_match #(.N(N), .IDX_W(IDX_W)) u_lk_match (
        .valid   (valid_q),
        .ents    (ents_q),
        .key_vpn (lk_vpn),
        .key_pid (lk_pid),
        .hit_vec (lk_vec),
        .any_hit (lk_any),
        .hit_idx (lk_idx)
    );

    assign lk_hit   = translate && lk_any;
    assign walk_req = translate && !lk_any;
    assign walk_vpn = lk_vpn;
    assign walk_pid = lk_pid;

    always_comb begin
        if (lk_valid && lk_bypass)
            lk_paddr = lk_vaddr[PA_W-1:0];
        else if (lk_hit)
            lk_paddr = {ents_q[lk_idx].ppn, lk_vaddr[OFF_W-1:0]};
        else
            lk_paddr = '0;
    end

    // ---------------- refill path ----------------
    assign prot_fault = fill_valid && !fill_allowed;

    xlb_match #(.N(N), .IDX_W(IDX_W)) u_fill_match (
        .valid   (valid_q),
        .ents    (ents_q),
        .key_vpn (fill_vpn),
        .key_pid (fill_pid),
        .hit_vec (dup_vec),
        .any_hit (dup_any),
        .hit_idx (dup_idx)
    );

    xlb_recency #(.N(N), .IDX_W(IDX_W)) u_recency (
        .clk     (clk),
        .rst     (rst),
        .ta_en   (lk_hit),
        .ta_idx  (lk_idx),
        .tb_en   (fill_ok),
        .tb_idx  (vic_idx),
        .lru_idx (lru_idx)
    );

    if (REPL == REPL_RANDOM) begin : g_rand
        logic [RNG_W-1:0] rng_q;
        logic [RNG_W-1:0] rng_mod;
        always_ff @(posedge clk) begin
            if (rst)
                rng_q <= 16'hACE1;
            else
                rng_q <= rng_step(rng_q);
        end
        assign rng_mod  = rng_q % RNG_W'(N);
        assign repl_idx = rng_mod[IDX_W-1:0];
    end else begin : g_lru
        assign repl_idx = lru_idx;
    end

    xlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .valid    (valid_q),
        .dup_any  (dup_any),
        .dup_idx  (dup_idx),
        .repl_idx (repl_idx),
        .has_free (has_free),
        .vic_idx  (vic_idx)
    );

    // ---------------- storage ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < N; i++)
                ents_q[i] <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_ok) begin
            valid_q[vic_idx] <= 1'b1;
            ents_q[vic_idx]  <= '{vpn: fill_vpn, pid: fill_pid, ppn: fill_ppn};
        end
    end

    // ---------------- assertions ----------------
    // R2: page offset passes through on a hit
    a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    // R10: a translation is never held in two entries
    a_r10_one_copy: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec) && $onehot0(dup_vec));

    // R7: a flush leaves nothing valid
    a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> valid_q == '0);

    // R6: a refused refill changes no valid bit
    a_r6_reject_hold: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_allowed && !flush) |=> $stable(valid_q));

    // R8: while space remains, a new translation lands in a free entry
    a_r8_free_first: assert property (@(posedge clk) disable iff (rst)
        (fill_ok && !dup_any && has_free) |-> !valid_q[vic_idx]);

    // R5: an accepted refill is valid afterwards
    a_r5_fill_lands: assert property (@(posedge clk) disable iff (rst)
        fill_ok |=> valid_q != '0);

    // R3: hit and walk request never together
    a_r3_walk_excl: assert property (@(posedge clk) disable iff (rst)
        !(walk_req && lk_hit));

endmodule

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_bypass = 0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        fill_valid = 0, fill_allowed = 0, flush = 0;
    logic [20:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [18:0] fill_ppn = '0;
    logic        lk_hit, walk_req, prot_fault;
    logic [29:0] lk_paddr;
    logic [20:0] walk_vpn;
    logic [7:0]  walk_pid;

    int checks = 0;
    int errors = 0;

    // reference model
    bit          m_valid [N];
    logic [20:0] m_vpn [N];
    logic [7:0]  m_pid [N];
    logic [18:0] m_ppn [N];
    int          order [$];

    always #2.5 clk = ~clk;

    xlat_buffer #(.N(N)) u_xlat_buffer (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_bypass(lk_bypass), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_pid(walk_pid),
        .fill_valid(fill_valid), .fill_allowed(fill_allowed),
        .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn),
        .prot_fault(prot_fault), .flush(flush)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int mfind(input logic [20:0] v, input logic [7:0] p);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == v && m_pid[i] == p) return i;
        return -1;
    endfunction

    task automatic touch(input int k);
        for (int j = 0; j < order.size(); j++)
            if (order[j] == k) begin order.delete(j); break; end
        order.push_front(k);
    endtask

    task automatic model_reset();
        order.delete();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0;
            order.push_back(i);
        end
    endtask

    task automatic model_step(input int hi);
        int vic;
        vic = -1;
        if (fill_valid && fill_allowed && !flush) begin
            vic = mfind(fill_vpn, fill_pid);
            if (vic < 0)
                for (int i = 0; i < N; i++)
                    if (!m_valid[i]) begin vic = i; break; end
            if (vic < 0) vic = order[N-1];
        end
        if (lk_valid && !lk_bypass && hi >= 0) touch(hi);
        if (vic >= 0) begin
            touch(vic);
            m_valid[vic] = 1;
            m_vpn[vic] = fill_vpn;
            m_pid[vic] = fill_pid;
            m_ppn[vic] = fill_ppn;
        end
        if (flush)
            for (int i = 0; i < N; i++) m_valid[i] = 0;
    endtask

    // one clock: compare at negedge+1, update model at posedge
    task automatic cyc(input string tag);
        int hi;
        logic        e_hit, e_walk, e_fault;
        logic [29:0] e_pa;
        hi = mfind(lk_vaddr[31:11], lk_pid);
        e_hit   = lk_valid && !lk_bypass && hi >= 0;
        e_walk  = lk_valid && !lk_bypass && hi < 0;
        e_fault = fill_valid && !fill_allowed;
        if (lk_valid && lk_bypass) e_pa = lk_vaddr[29:0];
        else if (e_hit)            e_pa = {m_ppn[hi], lk_vaddr[10:0]};
        else                       e_pa = '0;
        #1;
        chk(tag, "lk_hit", 32'(lk_hit), 32'(e_hit));
        chk(tag, "lk_paddr", 32'(lk_paddr), 32'(e_pa));
        chk(tag, "walk_req", 32'(walk_req), 32'(e_walk));
        chk(tag, "prot_fault", 32'(prot_fault), 32'(e_fault));
        if (e_walk) begin
            chk(tag, "walk_vpn", 32'(walk_vpn), 32'(lk_vaddr[31:11]));
            chk(tag, "walk_pid", 32'(walk_pid), 32'(lk_pid));
        end
        @(posedge clk);
        if (!rst) model_step(hi);
        @(negedge clk);
    endtask

    task automatic idle();
        lk_valid = 0; lk_bypass = 0; fill_valid = 0; fill_allowed = 0; flush = 0;
    endtask

    task automatic look(input logic [20:0] v, input logic [7:0] p, input logic [10:0] off);
        lk_valid = 1; lk_bypass = 0; lk_vaddr = {v, off}; lk_pid = p;
    endtask

    task automatic fill(input logic [20:0] v, input logic [7:0] p, input logic [18:0] pp, input logic ok);
        fill_valid = 1; fill_allowed = ok; fill_vpn = v; fill_pid = p; fill_ppn = pp;
    endtask

    task automatic probe_all(input string tag, input logic [7:0] p);
        for (int v = 'h100; v < 'h114; v++) begin
            idle(); look(21'(v), p, 11'h2A5); cyc(tag);
        end
        idle();
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst = 0;
        look(21'h01234, 8'd5, 11'h7FF); cyc("R1");
        look(21'h1FFFFF, 8'd0, 11'h000); cyc("R3");

        // refill then lookup in the same cycle sees the old contents
        idle(); fill(21'h01234, 8'd5, 19'h0ABC, 1); look(21'h01234, 8'd5, 11'h123); cyc("R12");
        idle(); look(21'h01234, 8'd5, 11'h123); cyc("R5");
        look(21'h01234, 8'd5, 11'h456); cyc("R2");
        look(21'h01234, 8'd6, 11'h456); cyc("R4");

        // refused refill
        idle(); fill(21'h02222, 8'd5, 19'h1111, 0); cyc("R6");
        idle(); look(21'h02222, 8'd5, 11'h0); cyc("R6");
        look(21'h01234, 8'd5, 11'h001); cyc("R6");

        // untranslated access
        idle(); lk_valid = 1; lk_bypass = 1; lk_vaddr = 32'hC123_4567; lk_pid = 8'd5; cyc("R11");
        lk_vaddr = {21'h01234, 11'h333}; cyc("R11");

        // fill the rest: free entries first
        idle();
        for (int v = 'h100; v < 'h10F; v++) begin
            fill(21'(v), 8'd7, 19'(v * 3), 1); cyc("R8");
        end
        idle(); probe_all("R8", 8'd7);

        // reorder use, then evict: LRU is entry 0 (vpn 01234) unless touched
        look(21'h01234, 8'd5, 11'h0); cyc("R9");
        look(21'h00100, 8'd7, 11'h0); cyc("R9");
        idle(); fill(21'h00200, 8'd7, 19'h2222, 1); cyc("R9");
        idle(); probe_all("R9", 8'd7);
        look(21'h01234, 8'd5, 11'h0); cyc("R9");
        look(21'h00200, 8'd7, 11'h0); cyc("R9");

        // duplicate refill overwrites in place
        idle(); fill(21'h00105, 8'd7, 19'h5A5A5, 1); cyc("R10");
        idle(); look(21'h00105, 8'd7, 11'h010); cyc("R10");
        probe_all("R10", 8'd7);

        // bypass does not refresh use order
        lk_valid = 1; lk_bypass = 1; lk_vaddr = {21'h00103, 11'h0}; lk_pid = 8'd7; cyc("R11");
        idle(); fill(21'h00300, 8'd7, 19'h3333, 1); cyc("R11");
        idle(); probe_all("R11", 8'd7);

        // hit and refill in one cycle on a full buffer
        look(21'h00104, 8'd7, 11'h0); fill(21'h00301, 8'd7, 19'h3434, 1); cyc("R12");
        idle(); fill(21'h00302, 8'd7, 19'h3535, 1); cyc("R9");
        idle(); probe_all("R9", 8'd7);
        look(21'h00301, 8'd7, 11'h0); cyc("R9");

        // flush together with a permitted refill; lookup in flush cycle still hits
        look(21'h00107, 8'd7, 11'h0); fill(21'h00400, 8'd7, 19'h4444, 1); flush = 1; cyc("R7");
        idle(); look(21'h00400, 8'd7, 11'h0); cyc("R7");
        probe_all("R7", 8'd7);
        fill(21'h00500, 8'd9, 19'h5555, 1); cyc("R8");
        idle(); look(21'h00500, 8'd9, 11'h1); cyc("R8");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            idle();
            if ($urandom_range(0, 3) != 0) begin
                look(21'($urandom_range(0, 23)), 8'($urandom_range(1, 2)), 11'($urandom));
                lk_bypass = ($urandom_range(0, 19) == 0);
            end
            if ($urandom_range(0, 2) == 0)
                fill(21'($urandom_range(0, 23)), 8'($urandom_range(1, 2)), 19'($urandom),
                     $urandom_range(0, 9) != 0);
            flush = ($urandom_range(0, 79) == 0);
            cyc("R9");
        end

        idle(); cyc("R12");
        summary();
        $finish;
    end

endmodule